// File: doc/BRIEF.md
# DDR3 CKE Power-State Sequencer

This block sits between a DDR3 controller's command scheduler and the device pins. It takes over the clock-enable line and the four command strobes whenever the memory goes into or comes out of a low-power state. A requester hands it one of four operations over a valid/ready channel: enter power-down, leave power-down, enter self-refresh or leave self-refresh. Two status inputs come from the rest of the controller. One says whether any bank is open. The other is a vector of in-flight operation flags: burst, mode-register write, precharge and refresh.

The sequencer checks each request against the current power state. On power-down entry it picks active or precharge power-down from the bank state. It pairs every CKE change with the only command allowed on that edge, and it refuses to move CKE again before the minimum hold time. After an exit it holds the bus at no-operation until the exit delay has run out. Separate flags report when ordinary commands and reads may go out again. A power-down flag tells the refresh scheduler that no refresh is happening, so that it can force an exit.

The request channel follows the usual valid/ready rules. The requester raises `req_valid` with `req_op` and keeps both stable until it sees `req_ready` high at a rising edge. The transfer happens on that edge. While `req_ready` is low the request waits and is never dropped. A request that is illegal in the current state still completes its handshake. It is then reported and discarded.

Top module: `ddr3_cke_seq`

## Requirements
- R1: After reset: `cke`=1, `power_state`=0 (idle), `cmd_ok`=1, `rd_ok`=1, `req_ready`=1, `pd_flag`=0, `req_err`=0, `bus_own`=0, and the strobes show deselect ({cs_n,ras_n,cas_n,we_n}=4'b1111).
- R2: A power-down entry (`req_op`=0) accepted in state 0 or 1 makes the next cycle show `cke`=0 with no-operation on the bus (4'b0111). The state becomes 2 (active power-down) if `bank_open` was high at the handshake edge, and 3 (precharge power-down) otherwise.
- R3: `pd_flag` is high exactly while the state is 2 or 3. Every cycle after the entry cycle in which `cke` is low shows deselect (4'b1111) on the strobes.
- R4: A self-refresh entry (`req_op`=2) is legal only in state 0 or 1 with `bank_open` low and every `op_busy` bit low. It then gives `cke`=0 together with refresh (4'b0001) in the next cycle, and the state becomes 4.
- R5: Two successive changes of `cke` are at least T_CKE cycles apart. A request that is held back to back after a change moves `cke` exactly T_CKE cycles after that change.
- R6: A power-down exit (`req_op`=1) from state 2 or 3 raises `cke` with no-operation and enters state 6. The strobes hold no-operation through state 6. `cmd_ok` is low for exactly T_XP cycles counted from the first cycle with `cke` high.
- R7: A self-refresh exit (`req_op`=3) from state 4 raises `cke` with no-operation and enters state 5, which holds no-operation on the strobes. `cmd_ok` stays low for exactly T_XS cycles and `rd_ok` for exactly T_XSDLL cycles, both counted from the first cycle with `cke` high.
- R8: Outside the low-power and exit states, the state follows `bank_open` one cycle later (1 if open, 0 if not), with `cmd_ok`=1 and `bus_own`=0.
- R9: `req_ready` is low while the CKE hold time runs and throughout states 5 and 6. A request held during that time is accepted on the first edge with `req_ready` high.
- R10: An accepted request that is illegal in the current state gives a one-cycle `req_err` pulse in the next cycle and leaves `cke` and the low-power state unchanged. Operation codes are 0 power-down entry, 1 power-down exit, 2 self-refresh entry and 3 self-refresh exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Low-power request present |
| req_op | input | 2 | Requested operation (0 PD enter, 1 PD exit, 2 SR enter, 3 SR exit) |
| req_ready | output | 1 | Request can be taken this cycle |
| bank_open | input | 1 | At least one bank is open |
| op_busy | input | BUSY_W | In-flight flags: burst, mode write, precharge, refresh |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select strobe |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write-enable strobe |
| bus_own | output | 1 | Sequencer is driving the command strobes |
| power_state | output | 3 | Power state code (0..6) |
| pd_flag | output | 1 | Device is in a power-down state (no refresh happening) |
| cmd_ok | output | 1 | Ordinary commands may be issued |
| rd_ok | output | 1 | Read commands may be issued |
| req_err | output | 1 | One-cycle pulse: last accepted request was illegal |

## Verification
Most internal faults show up on the port pins within one cycle of the handshake. A wrong legality decision produces an error pulse where none belongs, or a CKE edge paired with the wrong strobes. A wrong bank-based choice leaves the wrong code on `power_state` and `pd_flag`. Counter faults only appear at the end of a window: a hold or exit counter that is off by one moves the next CKE edge, or the rise of `cmd_ok` or `rd_ok`, by one cycle. The bench therefore measures these edges to the exact cycle instead of only watching for a late timeout.

// File: rtl/cke_seq_pkg.sv
package cke_seq_pkg;

  typedef enum logic [2:0] {
    PS_IDLE     = 3'd0,
    PS_ACTIVE   = 3'd1,
    PS_ACT_PD   = 3'd2,
    PS_PRE_PD   = 3'd3,
    PS_SELF_REF = 3'd4,
    PS_SR_EXIT  = 3'd5,
    PS_PD_EXIT  = 3'd6
  } pstate_e;

  typedef enum logic [1:0] {
    OP_PD_ENTER = 2'd0,
    OP_PD_EXIT  = 2'd1,
    OP_SR_ENTER = 2'd2,
    OP_SR_EXIT  = 2'd3
  } lp_op_e;

  // strobe order: chip select, row, column, write enable (all active low)
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_bus_t;

  localparam cmd_bus_t CMD_DESEL = 4'b1111;
  localparam cmd_bus_t CMD_NOP   = 4'b0111;
  localparam cmd_bus_t CMD_REF   = 4'b0001;

endpackage

// File: rtl/cke_dn_timer.sv
module cke_dn_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/cke_req_check.sv
module cke_req_check
  import cke_seq_pkg::*;
#(
  parameter int BUSY_W = 4
) (
  input  lp_op_e            op,
  input  pstate_e           cur,
  input  logic              bank_open,
  input  logic [BUSY_W-1:0] busy,
  output logic              legal,
  output pstate_e           nxt,
  output logic              nxt_cke,
  output cmd_bus_t          lead_cmd
);
  logic normal;

  assign normal = (cur == PS_IDLE) || (cur == PS_ACTIVE);

  always_comb begin
    legal    = 1'b0;
    nxt      = cur;
    nxt_cke  = 1'b1;
    lead_cmd = CMD_NOP;
    case (op)
      OP_PD_ENTER: begin
        legal   = normal;
        nxt     = bank_open ? PS_ACT_PD : PS_PRE_PD;
        nxt_cke = 1'b0;
      end
      OP_PD_EXIT: begin
        legal = (cur == PS_ACT_PD) || (cur == PS_PRE_PD);
        nxt   = PS_PD_EXIT;
      end
      OP_SR_ENTER: begin
        legal    = normal && !bank_open && (busy == '0);
        nxt      = PS_SELF_REF;
        nxt_cke  = 1'b0;
        lead_cmd = CMD_REF;
      end
      default: begin
        legal = (cur == PS_SELF_REF);
        nxt   = PS_SR_EXIT;
      end
    endcase
  end
endmodule

// File: rtl/ddr3_cke_seq.sv
module ddr3_cke_seq
  import cke_seq_pkg::*;
#(
  parameter int T_CKE   = 3,
  parameter int T_XP    = 4,
  parameter int T_XS    = 96,
  parameter int T_XSDLL = 512,
  parameter int BUSY_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  output logic              req_ready,
  input  logic              bank_open,
  input  logic [BUSY_W-1:0] op_busy,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              bus_own,
  output logic [2:0]        power_state,
  output logic              pd_flag,
  output logic              cmd_ok,
  output logic              rd_ok,
  output logic              req_err
);
  // T_XSDLL is the longest window; every other load fits its width
  localparam int CW = $clog2(T_XSDLL + 1);

  pstate_e  state_q, state_d, nxt_state;
  cmd_bus_t cmd_q, lead_cmd;
  lp_op_e   op;
  logic     cke_q, err_q;
  logic     legal, nxt_cke, fire, accept, in_wait;
  logic     hold_done, exit_done, dll_done;
  logic     exit_load, dll_load;
  logic [CW-1:0] exit_val;

  assign op      = lp_op_e'(req_op);
  assign in_wait = (state_q == PS_SR_EXIT) || (state_q == PS_PD_EXIT);
  assign req_ready = hold_done && !in_wait;
  assign fire    = req_valid && req_ready;
  assign accept  = fire && legal;

  cke_req_check #(.BUSY_W(BUSY_W)) check_i (
    .op        (op),
    .cur       (state_q),
    .bank_open (bank_open),
    .busy      (op_busy),
    .legal     (legal),
    .nxt       (nxt_state),
    .nxt_cke   (nxt_cke),
    .lead_cmd  (lead_cmd)
  );

  // CKE hold window: ready again T_CKE cycles after the change
  cke_dn_timer #(.W(CW)) hold_tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (CW'(T_CKE - 1)),
    .done     (hold_done)
  );

  assign exit_load = accept && (op == OP_PD_EXIT || op == OP_SR_EXIT);
  assign exit_val  = (op == OP_PD_EXIT) ? CW'(T_XP - 1) : CW'(T_XS - 1);

  cke_dn_timer #(.W(CW)) exit_tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (exit_load),
    .load_val (exit_val),
    .done     (exit_done)
  );

  assign dll_load = accept && (op == OP_SR_EXIT);

  cke_dn_timer #(.W(CW)) dll_tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dll_load),
    .load_val (CW'(T_XSDLL)),
    .done     (dll_done)
  );

  always_comb begin
    state_d = state_q;
    if (accept) begin
      state_d = nxt_state;
    end else begin
      case (state_q)
        PS_IDLE, PS_ACTIVE:
          state_d = bank_open ? PS_ACTIVE : PS_IDLE;
        PS_SR_EXIT, PS_PD_EXIT:
          if (exit_done) state_d = bank_open ? PS_ACTIVE : PS_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      cke_q   <= 1'b1;
      cmd_q   <= CMD_DESEL;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= fire && !legal;
      if (accept) begin
        cke_q <= nxt_cke;
        cmd_q <= lead_cmd;
      end else if (state_d == PS_SR_EXIT || state_d == PS_PD_EXIT) begin
        cmd_q <= CMD_NOP;
      end else begin
        cmd_q <= CMD_DESEL;
      end
    end
  end

  assign cke         = cke_q;
  assign cs_n        = cmd_q.cs_n;
  assign ras_n       = cmd_q.ras_n;
  assign cas_n       = cmd_q.cas_n;
  assign we_n        = cmd_q.we_n;
  assign power_state = state_q;
  assign bus_own     = !(state_q == PS_IDLE || state_q == PS_ACTIVE);
  assign pd_flag     = (state_q == PS_ACT_PD) || (state_q == PS_PRE_PD);
  assign cmd_ok      = (state_q == PS_IDLE) || (state_q == PS_ACTIVE);
  assign rd_ok       = cmd_ok && dll_done;
  assign req_err     = err_q;
endmodule

// File: rtl/ddr3_cke_seq_chk.sv
module ddr3_cke_seq_chk #(
  parameter int T_CKE  = 3,
  parameter int BUSY_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              bank_open,
  input logic [BUSY_W-1:0] op_busy,
  input logic [2:0]        power_state,
  input logic              pd_flag,
  input logic              cmd_ok,
  input logic              rd_ok,
  input logic              req_err
);
  localparam int RW = $clog2(T_CKE + 2);

  logic          prev_cke;
  logic [RW-1:0] run_q;
  logic          is_nop, is_ref, in_wait;

  assign is_nop  = !cs_n && ras_n && cas_n && we_n;
  assign is_ref  = !cs_n && !ras_n && !cas_n && we_n;
  assign in_wait = (power_state == 3'd5) || (power_state == 3'd6);

  // length of the run of equal cke values ending in the previous cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cke <= 1'b1;
      run_q    <= RW'(T_CKE);
    end else begin
      prev_cke <= cke;
      if (cke != prev_cke)            run_q <= RW'(1);
      else if (run_q < RW'(T_CKE))    run_q <= run_q + 1'b1;
    end
  end

  p_cke_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cke != prev_cke) |-> (run_q >= RW'(T_CKE)));

  p_cke_edge_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cke != $past(cke)) |-> (is_nop || (!cke && is_ref)));

  p_sr_entry_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cke) && is_ref) |-> $past(!bank_open && (op_busy == '0)));

  p_pd_flag_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pd_flag |-> !cke);

  p_exit_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (cke && is_nop && !cmd_ok));

  p_read_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |-> (cmd_ok && cke));

  p_err_no_cke_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $stable(cke));
endmodule

bind ddr3_cke_seq ddr3_cke_seq_chk #(.T_CKE(T_CKE), .BUSY_W(BUSY_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .bank_open   (bank_open),
  .op_busy     (op_busy),
  .power_state (power_state),
  .pd_flag     (pd_flag),
  .cmd_ok      (cmd_ok),
  .rd_ok       (rd_ok),
  .req_err     (req_err)
);

// File: tb/ddr3_cke_seq_tb_top.sv
module ddr3_cke_seq_tb_top;
  localparam int TB_CKE   = 3;
  localparam int TB_XP    = 4;
  localparam int TB_XS    = 9;
  localparam int TB_XSDLL = 15;
  localparam int CMD_NOP_V = 7, CMD_REF_V = 1, CMD_DES_V = 15;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_op;
  logic       req_ready;
  logic       bank_open;
  logic [3:0] op_busy;
  logic       cke, cs_n, ras_n, cas_n, we_n, bus_own;
  logic [2:0] power_state;
  logic       pd_flag, cmd_ok, rd_ok, req_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr3_cke_seq #(.T_CKE(TB_CKE), .T_XP(TB_XP), .T_XS(TB_XS),
                 .T_XSDLL(TB_XSDLL), .BUSY_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_ready(req_ready), .bank_open(bank_open), .op_busy(op_busy),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bus_own(bus_own), .power_state(power_state), .pd_flag(pd_flag),
    .cmd_ok(cmd_ok), .rd_ok(rd_ok), .req_err(req_err)
  );

  function automatic int bus_word();
    return {28'd0, cs_n, ras_n, cas_n, we_n};
  endfunction

  function automatic bit op_legal(int op, int st, bit bo, logic [3:0] busy);
    bit normal = (st == 0 || st == 1);
    case (op)
      0: return normal;
      1: return (st == 2 || st == 3);
      2: return normal && !bo && (busy == 4'd0);
      default: return (st == 4);
    endcase
  endfunction

  function automatic int op_next(int op, bit bo);
    case (op)
      0: return bo ? 2 : 3;
      1: return 6;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // called at a falling edge; returns in the first cycle after acceptance
  task automatic do_req(input int op, output int stall);
    stall = 0;
    req_valid = 1'b1;
    req_op = 2'(op);
    while (!req_ready) begin
      @(negedge clk);
      stall++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int st, f, r;
    bit exp_v, exp_err, will_fire, prev_cke;
    int exp_st, exp_cke, last_chg;

    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0;
    bank_open = 1'b0; op_busy = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cke", cke, 1);
    chk("R1 state", power_state, 0);
    chk("R1 cmd_ok", cmd_ok, 1);
    chk("R1 rd_ok", rd_ok, 1);
    chk("R1 ready", req_ready, 1);
    chk("R1 pd_flag", pd_flag, 0);
    chk("R1 err", req_err, 0);
    chk("R1 bus_own", bus_own, 0);
    chk("R1 strobes", bus_word(), CMD_DES_V);

    // R8 state follows bank_open
    bank_open = 1'b1;
    @(negedge clk);
    chk("R8 active", power_state, 1);
    chk("R8 cmd_ok", cmd_ok, 1);

    // R2 active power-down entry
    do_req(0, st);
    f = cyc;
    chk("R2 cke low", cke, 0);
    chk("R2 act pd", power_state, 2);
    chk("R2 nop", bus_word(), CMD_NOP_V);
    chk("R3 pd_flag", pd_flag, 1);
    chk("R2 cmd_ok", cmd_ok, 0);
    @(negedge clk);
    chk("R3 deselect", bus_word(), CMD_DES_V);

    // R5 R9 back-to-back exit waits for hold time
    do_req(1, st);
    r = cyc;
    chk("R5 hold gap", r - f, TB_CKE);
    chk("R9 stall", st, TB_CKE - 2);
    chk("R6 exit state", power_state, 6);
    chk("R6 cke high", cke, 1);
    chk("R3 pd_flag off", pd_flag, 0);
    for (int k = 0; k <= TB_XP; k++) begin
      chk("R6 cmd_ok window", cmd_ok, (k >= TB_XP) ? 1 : 0);
      if (k < TB_XP) chk("R6 nop", bus_word(), CMD_NOP_V);
      if (k < TB_XP) @(negedge clk);
    end
    chk("R8 back active", power_state, 1);

    // R2 precharge power-down
    bank_open = 1'b0;
    @(negedge clk);
    do_req(0, st);
    chk("R2 pre pd", power_state, 3);
    chk("R3 pd_flag pre", pd_flag, 1);
    do_req(1, st);
    while (!cmd_ok) @(negedge clk);
    chk("R8 idle", power_state, 0);

    // R10 illegal requests
    bank_open = 1'b1;
    @(negedge clk);
    do_req(2, st);
    chk("R10 err open bank", req_err, 1);
    chk("R10 cke kept", cke, 1);
    chk("R10 state kept", power_state, 1);
    @(negedge clk);
    chk("R10 err pulse", req_err, 0);
    bank_open = 1'b0;
    for (int b = 0; b < 4; b++) begin
      op_busy = 4'(1 << b);
      @(negedge clk);
      do_req(2, st);
      chk("R4 busy refuse", req_err, 1);
      chk("R4 busy cke", cke, 1);
    end
    op_busy = 4'd0;
    do_req(1, st);
    chk("R10 exit while idle", req_err, 1);

    // R4 legal self-refresh entry
    @(negedge clk);
    do_req(2, st);
    chk("R4 cke low", cke, 0);
    chk("R4 refresh", bus_word(), CMD_REF_V);
    chk("R4 state", power_state, 4);
    chk("R4 pd_flag", pd_flag, 0);
    @(negedge clk);
    chk("R4 deselect", bus_word(), CMD_DES_V);
    do_req(0, st);
    chk("R10 pd in sr", req_err, 1);
    chk("R10 sr kept", power_state, 4);
    chk("R10 sr cke", cke, 0);

    // R7 self-refresh exit windows
    do_req(3, st);
    chk("R7 state", power_state, 5);
    for (int k = 0; k <= TB_XSDLL; k++) begin
      chk("R7 cmd_ok window", cmd_ok, (k >= TB_XS) ? 1 : 0);
      chk("R7 rd_ok window", rd_ok, (k >= TB_XSDLL) ? 1 : 0);
      if (k < TB_XS) chk("R7 nop", bus_word(), CMD_NOP_V);
      if (k < TB_XSDLL) @(negedge clk);
    end

    // R9 request queued during exit wait is kept
    do_req(2, st);
    do_req(3, st);
    r = cyc;
    req_valid = 1'b1;
    req_op = 2'd0;
    chk("R9 ready low", req_ready, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 late entry", cyc - r, TB_XS + 1);
    chk("R9 entry cke", cke, 0);
    chk("R9 entry state", power_state, 3);
    do_req(1, st);
    while (!cmd_ok) @(negedge clk);

    // constrained random phase
    process::self().srandom(32'h5eed_0042);
    exp_v = 0; will_fire = 0; prev_cke = cke; last_chg = -100;
    exp_err = 0; exp_st = 0; exp_cke = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (exp_v) begin
        chk("R10 err flag", req_err, exp_err ? 1 : 0);
        if (!exp_err) begin
          chk("R2 R4 R6 R7 next state", power_state, exp_st);
          chk("R2 R4 R6 R7 next cke", cke, exp_cke);
        end else begin
          chk("R10 cke unchanged", cke, prev_cke);
        end
      end
      chk("R3 pd_flag", pd_flag, (power_state == 2 || power_state == 3) ? 1 : 0);
      if (cke != prev_cke) begin
        chk("R5 gap ok", (cyc - last_chg >= TB_CKE) ? 1 : 0, 1);
        chk("R2 edge cmd", (bus_word() == CMD_NOP_V ||
                            (!cke && bus_word() == CMD_REF_V)) ? 1 : 0, 1);
        last_chg = cyc;
        prev_cke = cke;
      end
      if (!(req_valid && !will_fire)) begin
        req_valid = ($urandom % 4) == 0;
        req_op = 2'($urandom % 4);
      end
      if (($urandom % 8) == 0) bank_open = ~bank_open;
      op_busy = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      will_fire = req_valid && req_ready;
      exp_v = will_fire;
      if (will_fire) begin
        exp_err = !op_legal(req_op, power_state, bank_open, op_busy);
        exp_st  = op_next(req_op, bank_open);
        exp_cke = req_op[0] ? 1 : 0;
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule